// File: doc/BRIEF.md
# Double-Buffered OUT Endpoint Packet Store

This block holds received data for one device-side OUT endpoint. Bytes arrive from the serial interface engine on a write strobe. An end-of-packet strobe closes the packet being received. Two packet slots of 256 bytes each work in ping-pong fashion. One slot can take in a new packet while the other is waiting or being drained. Both slots can also hold finished packets at the same time.

When a packet is closed, the block pulses an interrupt and raises a DMA request. The DMA request stays high while a packet is available. The processor or DMA engine then drains the oldest finished packet one byte at a time through an 8-bit read port. A remaining-byte count and a ready flag describe the packet at the head.

A NAK output tells the protocol engine to refuse the next OUT token. It does so while both slots hold finished packets, and it stays asserted until a whole slot has been emptied. Bytes beyond the slot size are discarded and flagged. The block uses an asynchronous active-low reset, which is expected to be released synchronously to the clock.

Top module: `usb_out_pingpong`

## Requirements
- R1: While reset is held, and after it is released, both slots are empty and pkt_ready, dma_req, nak, irq and rx_ovf are low. head_count reads 0.
- R2: Each byte is read back in the order it was written. rd_data always shows the head byte of the oldest finished packet. A cycle with rd_en high consumes that byte, and the next byte appears in the following cycle.
- R3: A packet keeps at most 256 bytes. Bytes written after 256 are discarded and set rx_ovf. rx_ovf stays set until the first byte of a later packet is accepted.
- R4: An rx_eop with at least one byte received closes the packet. If the packet becomes the head, pkt_ready is high in the next cycle. head_count always equals the bytes still unread in the head packet. An rx_eop with no bytes received has no effect.
- R5: irq is high for exactly one cycle, the cycle after each packet is closed. dma_req is high exactly while pkt_ready is high.
- R6: While both slots hold finished packets, incoming bytes and rx_eop are discarded. The two stored packets are left unchanged.
- R7: nak is high exactly while both slots hold finished packets. It stays high through partial reads of the head packet and falls in the cycle after its last byte is read.
- R8: When no packet is ready, rd_data is 0. A read strobe then changes nothing.
- R9: Packets are delivered oldest first. After the head packet is drained, the other stored packet becomes the head in the next cycle.
- R10: A byte written in the same cycle as rx_eop is the last byte of the packet being closed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_we | input | 1 | Received byte strobe from the serial engine |
| rx_byte | input | 8 | Received byte |
| rx_eop | input | 1 | End of the packet being received |
| rd_en | input | 1 | Consume the head byte |
| rd_data | output | 8 | Head byte of the oldest finished packet, 0 when none |
| pkt_ready | output | 1 | A finished packet is available |
| head_count | output | 9 | Unread bytes left in the head packet |
| nak | output | 1 | Refuse the next OUT token |
| irq | output | 1 | One-cycle pulse per closed packet |
| dma_req | output | 1 | DMA service request |
| rx_ovf | output | 1 | Bytes of the current packet were discarded |

## Verification
The assertions assume only that the inputs are known after reset. They do not assume the protocol engine obeys nak, so writes during NAK, reads with no packet ready, and end-of-packet strobes with no bytes are all legal. The stimulus deliberately exercises these cases. The directed phases push a packet past 256 bytes, send a third packet while both slots are full, and reset in the middle of a transfer. A long random phase mixes short packets with reads so that closes and frees often fall in the same cycle.

// File: rtl/usbob_pkg.sv
package usbob_pkg;
  localparam int unsigned NUM_SLOTS = 2;
  typedef logic slot_sel_t;
  typedef logic [NUM_SLOTS-1:0] slot_vec_t;
endpackage

// File: rtl/ob_rx_ctrl.sv
module ob_rx_ctrl
  import usbob_pkg::*;
#(
  parameter int unsigned DEPTH = 256,
  parameter int unsigned AW    = $clog2(DEPTH),
  parameter int unsigned CW    = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic          eop,
  input  slot_vec_t     slot_full,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output slot_sel_t     fill_sel,
  output logic          commit,
  output logic [CW-1:0] commit_cnt,
  output logic          ovf
);
  slot_sel_t     sel_q, sel_d;
  logic [CW-1:0] cnt_q, cnt_d, cnt_inc;
  logic          ovf_q, ovf_d;
  logic          slot_open, room, drop, upd_en;

  always_comb begin
    slot_open = !slot_full[sel_q];
    room      = cnt_q < CW'(DEPTH);
    mem_we    = wr_en && slot_open && room;
    drop      = wr_en && slot_open && !room;
    cnt_inc   = cnt_q + CW'(mem_we);
    commit    = eop && slot_open && (cnt_inc != '0);
    upd_en    = mem_we || drop || commit;
    sel_d     = commit ? ~sel_q : sel_q;
    cnt_d     = commit ? '0 : cnt_inc;
    if (mem_we && (cnt_q == '0)) ovf_d = 1'b0;
    else if (drop)               ovf_d = 1'b1;
    else                         ovf_d = ovf_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q <= 1'b0;
      cnt_q <= '0;
      ovf_q <= 1'b0;
    end else if (upd_en) begin
      sel_q <= sel_d;
      cnt_q <= cnt_d;
      ovf_q <= ovf_d;
    end
  end

  assign mem_addr   = cnt_q[AW-1:0];
  assign fill_sel   = sel_q;
  assign commit_cnt = cnt_inc;
  assign ovf        = ovf_q;
endmodule

// File: rtl/ob_rd_ctrl.sv
module ob_rd_ctrl
  import usbob_pkg::*;
#(
  parameter int unsigned DEPTH = 256,
  parameter int unsigned AW    = $clog2(DEPTH),
  parameter int unsigned CW    = $clog2(DEPTH + 1)
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          rd_en,
  input  slot_vec_t                     slot_full,
  input  logic [NUM_SLOTS-1:0][CW-1:0]  slot_cnt,
  output slot_sel_t                     head_sel,
  output logic [AW-1:0]                 rd_addr,
  output logic                          head_full,
  output logic                          free,
  output logic [CW-1:0]                 head_left
);
  slot_sel_t     sel_q, sel_d;
  logic [CW-1:0] ptr_q, ptr_d, head_cnt;
  logic          do_rd, last;

  always_comb begin
    head_full = slot_full[sel_q];
    head_cnt  = slot_cnt[sel_q];
    do_rd     = rd_en && head_full;
    last      = (ptr_q + CW'(1)) == head_cnt;
    free      = do_rd && last;
    ptr_d     = last ? '0 : ptr_q + CW'(1);
    sel_d     = last ? ~sel_q : sel_q;
    head_left = head_full ? (head_cnt - ptr_q) : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q <= 1'b0;
      ptr_q <= '0;
    end else if (do_rd) begin
      sel_q <= sel_d;
      ptr_q <= ptr_d;
    end
  end

  assign head_sel = sel_q;
  assign rd_addr  = ptr_q[AW-1:0];
endmodule

// File: rtl/ob_slot.sv
module ob_slot
  import usbob_pkg::*;
#(
  parameter int unsigned IDX   = 0,
  parameter int unsigned DEPTH = 256,
  parameter int unsigned DW    = 8,
  parameter int unsigned AW    = $clog2(DEPTH),
  parameter int unsigned CW    = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  slot_sel_t     fill_sel,
  input  logic          mem_we,
  input  logic [AW-1:0] mem_addr,
  input  logic [DW-1:0] wr_data,
  input  logic          commit,
  input  logic [CW-1:0] commit_cnt,
  input  slot_sel_t     head_sel,
  input  logic          free,
  input  logic [AW-1:0] rd_addr,
  output logic          full,
  output logic [CW-1:0] cnt,
  output logic [DW-1:0] rdata
);
  localparam slot_sel_t MY_ID = slot_sel_t'(IDX);

  logic [DW-1:0] mem [DEPTH];
  logic          full_q, full_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          fill_me, drain_me, upd_en;

  always_comb begin
    fill_me  = commit && (fill_sel == MY_ID);
    drain_me = free && (head_sel == MY_ID);
    upd_en   = fill_me || drain_me;
    full_d   = full_q;
    cnt_d    = cnt_q;
    if (fill_me) begin
      full_d = 1'b1;
      cnt_d  = commit_cnt;
    end else if (drain_me) begin
      full_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      full_q <= 1'b0;
      cnt_q  <= '0;
    end else if (upd_en) begin
      full_q <= full_d;
      cnt_q  <= cnt_d;
    end
  end

  always_ff @(posedge clk) begin
    if (mem_we && (fill_sel == MY_ID)) mem[mem_addr] <= wr_data;
  end

  assign full  = full_q;
  assign cnt   = cnt_q;
  assign rdata = mem[rd_addr];
endmodule

// File: rtl/usb_out_pingpong.sv
module usb_out_pingpong
  import usbob_pkg::*;
#(
  parameter int unsigned DEPTH = 256,
  parameter int unsigned DW    = 8
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         rx_we,
  input  logic [DW-1:0]                rx_byte,
  input  logic                         rx_eop,
  input  logic                         rd_en,
  output logic [DW-1:0]                rd_data,
  output logic                         pkt_ready,
  output logic [$clog2(DEPTH+1)-1:0]   head_count,
  output logic                         nak,
  output logic                         irq,
  output logic                         dma_req,
  output logic                         rx_ovf
);
  localparam int unsigned AW = $clog2(DEPTH);
  localparam int unsigned CW = $clog2(DEPTH + 1);

  slot_vec_t                     slot_full;
  logic [NUM_SLOTS-1:0][CW-1:0]  slot_cnt;
  logic [NUM_SLOTS-1:0][DW-1:0]  slot_rdata;
  logic                          mem_we, commit, free, head_full;
  logic [AW-1:0]                 mem_addr, rd_addr;
  logic [CW-1:0]                 commit_cnt, head_left;
  slot_sel_t                     fill_sel, head_sel;
  logic                          irq_q, irq_d;

  ob_rx_ctrl #(.DEPTH(DEPTH), .AW(AW), .CW(CW)) u_rx (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (rx_we),
    .eop        (rx_eop),
    .slot_full  (slot_full),
    .mem_we     (mem_we),
    .mem_addr   (mem_addr),
    .fill_sel   (fill_sel),
    .commit     (commit),
    .commit_cnt (commit_cnt),
    .ovf        (rx_ovf)
  );

  ob_rd_ctrl #(.DEPTH(DEPTH), .AW(AW), .CW(CW)) u_rd (
    .clk       (clk),
    .rst_n     (rst_n),
    .rd_en     (rd_en),
    .slot_full (slot_full),
    .slot_cnt  (slot_cnt),
    .head_sel  (head_sel),
    .rd_addr   (rd_addr),
    .head_full (head_full),
    .free      (free),
    .head_left (head_left)
  );

  for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_slot
    ob_slot #(.IDX(g), .DEPTH(DEPTH), .DW(DW), .AW(AW), .CW(CW)) u_slot (
      .clk        (clk),
      .rst_n      (rst_n),
      .fill_sel   (fill_sel),
      .mem_we     (mem_we),
      .mem_addr   (mem_addr),
      .wr_data    (rx_byte),
      .commit     (commit),
      .commit_cnt (commit_cnt),
      .head_sel   (head_sel),
      .free       (free),
      .rd_addr    (rd_addr),
      .full       (slot_full[g]),
      .cnt        (slot_cnt[g]),
      .rdata      (slot_rdata[g])
    );
  end

  always_comb irq_d = commit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_q <= 1'b0;
    else        irq_q <= irq_d;
  end

  assign rd_data    = head_full ? slot_rdata[head_sel] : '0;
  assign pkt_ready  = head_full;
  assign dma_req    = head_full;
  assign head_count = head_left;
  assign nak        = &slot_full;
  assign irq        = irq_q;
endmodule

// File: rtl/ob_chk.sv
module ob_chk #(
  parameter int unsigned DEPTH = 256,
  parameter int unsigned DW    = 8,
  parameter int unsigned CW    = $clog2(DEPTH + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          rx_we,
  input logic          rx_eop,
  input logic          rd_en,
  input logic [DW-1:0] rd_data,
  input logic          pkt_ready,
  input logic [CW-1:0] head_count,
  input logic          nak,
  input logic          irq,
  input logic          dma_req,
  input logic          rx_ovf
);
  // R1: quiet outputs while reset is held
  always @(posedge clk) begin
    if (!rst_n) begin
      p_reset_quiet_r1: assert (!pkt_ready && !nak && !irq && !dma_req && !rx_ovf);
    end
  end

  // R2: a read inside a packet takes exactly one byte off the head count
  p_read_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && pkt_ready && head_count > CW'(1)) |=> head_count == $past(head_count) - CW'(1));

  // R3: the head never claims more than one slot's worth of bytes
  p_count_cap_r3: assert property (@(posedge clk) disable iff (!rst_n)
    head_count <= CW'(DEPTH));

  // R4: a ready packet always has bytes left
  p_ready_nonempty_r4: assert property (@(posedge clk) disable iff (!rst_n)
    pkt_ready |-> head_count != '0);

  // R5: an interrupt follows an end-of-packet strobe
  p_irq_after_eop_r5: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> $past(rx_eop));

  // R5: service request only with something to drain
  p_dma_has_data_r5: assert property (@(posedge clk) disable iff (!rst_n)
    dma_req |-> head_count != '0);

  // R7: refusing the host implies a waiting packet
  p_nak_needs_ready_r7: assert property (@(posedge clk) disable iff (!rst_n)
    nak |-> pkt_ready);

  // R7: nak only drops after the final byte of the head packet is taken
  p_nak_release_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(nak) |-> $past(rd_en && head_count == CW'(1)));

  // R8: nothing to read returns zero
  p_empty_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !pkt_ready |-> rd_data == '0);
endmodule

bind usb_out_pingpong ob_chk #(.DEPTH(DEPTH), .DW(DW)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .rx_we      (rx_we),
  .rx_eop     (rx_eop),
  .rd_en      (rd_en),
  .rd_data    (rd_data),
  .pkt_ready  (pkt_ready),
  .head_count (head_count),
  .nak        (nak),
  .irq        (irq),
  .dma_req    (dma_req),
  .rx_ovf     (rx_ovf)
);

// File: tb/tb_usb_out_pingpong.sv
module tb_usb_out_pingpong;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 256;

  logic       clk;
  logic       rst_n;
  logic       rx_we;
  logic [7:0] rx_byte;
  logic       rx_eop;
  logic       rd_en;
  logic [7:0] rd_data;
  logic       pkt_ready;
  logic [8:0] head_count;
  logic       nak;
  logic       irq;
  logic       dma_req;
  logic       rx_ovf;

  usb_out_pingpong #(.DEPTH(DEPTH), .DW(8)) dut (
    .clk(clk), .rst_n(rst_n), .rx_we(rx_we), .rx_byte(rx_byte), .rx_eop(rx_eop),
    .rd_en(rd_en), .rd_data(rd_data), .pkt_ready(pkt_ready), .head_count(head_count),
    .nak(nak), .irq(irq), .dma_req(dma_req), .rx_ovf(rx_ovf)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  int    checks = 0;
  int    fails  = 0;
  bit    done   = 0;
  string phase  = "R1";

  // behavioural reference: finished packet lengths, their bytes in order, packet in progress
  int         m_lens[$];
  logic [7:0] m_data[$];
  logic [7:0] m_cur[$];
  int         m_rd_off;
  bit         m_ovf, m_irq, live;

  task automatic chk(input string what, input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s phase=%s actual=%0d expected=%0d t=%0t", req, what, phase, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      m_lens.delete(); m_data.delete(); m_cur.delete();
      m_rd_off = 0; m_ovf = 0; m_irq = 0; live = 0;
    end else begin
      bit can_rx, was_ready;
      live      = 1;
      can_rx    = m_lens.size() < 2;
      was_ready = m_lens.size() > 0;
      m_irq     = 0;
      if (rx_we && can_rx) begin
        if (m_cur.size() < DEPTH) begin
          if (m_cur.size() == 0) m_ovf = 0;
          m_cur.push_back(rx_byte);
        end else m_ovf = 1;
      end
      if (rd_en && was_ready) begin
        void'(m_data.pop_front());
        m_rd_off++;
        if (m_rd_off == m_lens[0]) begin
          void'(m_lens.pop_front());
          m_rd_off = 0;
        end
      end
      if (rx_eop && can_rx && m_cur.size() > 0) begin
        m_lens.push_back(m_cur.size());
        foreach (m_cur[i]) m_data.push_back(m_cur[i]);
        m_cur.delete();
        m_irq = 1;
      end
    end
  end

  always @(negedge clk) begin
    if (live && rst_n && !done) begin
      int ready_e;
      ready_e = (m_lens.size() > 0) ? 1 : 0;
      chk("rd_data",    "R2", int'(rd_data),    ready_e ? int'(m_data[0]) : 0);
      chk("pkt_ready",  "R4", int'(pkt_ready),  ready_e);
      chk("head_count", "R4", int'(head_count), ready_e ? m_lens[0] - m_rd_off : 0);
      chk("nak",        "R7", int'(nak),        (m_lens.size() == 2) ? 1 : 0);
      chk("irq",        "R5", int'(irq),        int'(m_irq));
      chk("dma_req",    "R5", int'(dma_req),    ready_e);
      chk("rx_ovf",     "R3", int'(rx_ovf),     int'(m_ovf));
    end
  end

  task automatic step(input logic we, input logic [7:0] d, input logic eop, input logic re);
    @(posedge clk); #1;
    rx_we = we; rx_byte = d; rx_eop = eop; rd_en = re;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(0, 8'h00, 0, 0);
  endtask

  task automatic send(input int len, input int seed, input bit eop_on_last);
    for (int i = 0; i < len; i++)
      step(1, 8'((seed + i * 7) & 8'hFF), (eop_on_last && i == len - 1), 0);
    if (!eop_on_last) step(0, 8'h00, 1, 0);
    step(0, 8'h00, 0, 0);
  endtask

  task automatic drain(input int n);
    for (int i = 0; i < n; i++) step(0, 8'h00, 0, 1);
    step(0, 8'h00, 0, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    rst_n = 0; rx_we = 0; rx_byte = 0; rx_eop = 0; rd_en = 0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    @(negedge clk);
    phase = "R1";
    chk("pkt_ready after reset", "R1", int'(pkt_ready), 0);
    chk("nak after reset",       "R1", int'(nak), 0);
    chk("irq after reset",       "R1", int'(irq), 0);
    chk("rx_ovf after reset",    "R1", int'(rx_ovf), 0);
    chk("head_count after reset","R1", int'(head_count), 0);

    phase = "R8";            // reads with nothing stored
    drain(4);
    chk("empty read data", "R8", int'(rd_data), 0);

    phase = "R4";            // end-of-packet with no bytes is ignored
    step(0, 8'h00, 1, 0); idle(2);
    chk("zero length ignored", "R4", int'(pkt_ready), 0);

    phase = "R2";            // single packet, separate end strobe
    send(5, 8'h30, 0);
    chk("count of first packet", "R4", int'(head_count), 5);
    drain(5);

    phase = "R10";           // last byte carried with the end strobe
    send(3, 8'h90, 1);
    chk("count with eop byte", "R10", int'(head_count), 3);
    drain(3);

    phase = "R7";            // two packets then partial reads hold nak
    send(4, 8'h11, 0);
    send(6, 8'h55, 1);
    chk("nak with two stored", "R7", int'(nak), 1);
    drain(3);
    chk("nak after partial read", "R7", int'(nak), 1);

    phase = "R6";            // third packet arrives while both slots are full
    send(5, 8'hC0, 1);
    chk("head unchanged after drop", "R6", int'(head_count), 1);

    phase = "R9";            // finish head, second packet follows
    drain(1);
    chk("nak released", "R7", int'(nak), 0);
    chk("next head length", "R9", int'(head_count), 6);
    drain(6);

    phase = "R3";            // oversized packet
    send(300, 8'h01, 0);
    chk("capped count", "R3", int'(head_count), DEPTH);
    chk("overflow flag", "R3", int'(rx_ovf), 1);
    drain(DEPTH);
    send(2, 8'h77, 1);
    chk("overflow cleared", "R3", int'(rx_ovf), 0);
    drain(2);

    phase = "R5";            // random traffic
    for (int i = 0; i < 6000; i++) begin
      int r;
      r = int'($urandom_range(0, 99));
      step(r < 55, 8'($urandom), (r >= 45 && r < 60), ($urandom_range(0, 99) < 40));
    end
    idle(2);

    phase = "R1";            // reset during activity
    send(4, 8'h21, 1);
    step(1, 8'h44, 0, 1);
    @(posedge clk); #1 rst_n = 0; rx_we = 0; rd_en = 0; rx_eop = 0;
    @(negedge clk);
    chk("ready during reset", "R1", int'(pkt_ready), 0);
    chk("nak during reset",   "R1", int'(nak), 0);
    @(posedge clk); #1 rst_n = 1;
    idle(2);
    chk("empty after reset", "R1", int'(head_count), 0);
    send(2, 8'hA0, 1);
    drain(2);
    idle(2);

    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule